// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a memory with two independently driven ports, a left one and a right one. Each port presents an active-low select and an address. When both ports are selected and point at the same location, the block gives that location to the port whose select and address were already steady when the other port arrived. It then pulls the other port's active-low busy flag down, so that port can stall or suppress its access. Whether an access reads or writes has no bearing on the decision.

The block uses one clock. A port "arrives" in the clock cycle in which its select or address last changed. The earlier arrival wins. If both ports arrive in the same cycle, the left port wins. The winner is recorded in a register and kept for as long as the collision lasts. When the collision ends, both flags return high.

Top module: `dp_collision_arb`

## Requirements
- R1: A synchronous active-high reset drives both busy flags high on the edge that samples it. It also makes both ports count as having changed on the first edge after reset.
- R2: While either select is high (inactive), both busy flags are high one clock later.
- R3: While both ports are selected on different addresses, both busy flags are high one clock later.
- R4: When a collision appears (both selects low, addresses equal), the port whose select and address did not change at that edge wins. The other port's busy flag is low after that same edge, which is one clock after the match appears.
- R5: If both ports changed at the edge where the collision appears, the left port wins and only the right busy flag goes low.
- R6: While the collision persists, the recorded winner is kept. This holds even when both ports move together to a new shared address.
- R7: When the addresses stop matching, the loser's busy flag returns high after the next edge.
- R8: When the winning port deselects, the loser's busy flag returns high after the next edge.
- R9: The two busy flags are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lt_sel_n | input | 1 | Left port select, active low |
| lt_addr | input | ADDR_W (11) | Left port address |
| rt_sel_n | input | 1 | Right port select, active low |
| rt_addr | input | ADDR_W (11) | Right port address |
| lt_busy_n | output | 1 | Left busy flag, low when the right port holds the location |
| rt_busy_n | output | 1 | Right busy flag, low when the left port holds the location |

## Verification
The bench drives the following input patterns:
- One side selected alone, and both selected on different addresses. These show that no false collision is raised.
- Collisions in which the left port arrives first, and collisions in which the right port arrives first. These separate a true first-arrival rule from a fixed preference for one side.
- A same-cycle arrival, which exposes the tie-break.
- A joint move of both ports to a new shared address. This shows whether the design holds its recorded winner or arbitrates again.
- Address divergence, and deselection by the winner. These check each release path.
- A reset in the middle of a collision.
- A long random run over a four-address space, which mixes all of the above.

// File: rtl/dp_collision_arb.sv
module dp_collision_arb #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lt_sel_n,
  input  logic [ADDR_W-1:0] lt_addr,
  input  logic              rt_sel_n,
  input  logic [ADDR_W-1:0] rt_addr,
  output logic              lt_busy_n,
  output logic              rt_busy_n
);

  logic              lt_sel_q, rt_sel_q;
  logic [ADDR_W-1:0] lt_addr_q, rt_addr_q;
  logic              hit, lt_new, rt_new, owned, rt_first;

  assign hit      = !lt_sel_n && !rt_sel_n && (lt_addr == rt_addr);
  assign lt_new   = (lt_sel_n != lt_sel_q) || (lt_addr != lt_addr_q);
  assign rt_new   = (rt_sel_n != rt_sel_q) || (rt_addr != rt_addr_q);
  assign owned    = !lt_busy_n || !rt_busy_n;
  // right wins only if it was steady while the left side just moved
  assign rt_first = lt_new && !rt_new;

  always_ff @(posedge clk) begin
    if (rst) begin
      lt_sel_q  <= 1'b1;
      rt_sel_q  <= 1'b1;
      lt_addr_q <= '0;
      rt_addr_q <= '0;
      lt_busy_n <= 1'b1;
      rt_busy_n <= 1'b1;
    end else begin
      lt_sel_q  <= lt_sel_n;
      rt_sel_q  <= rt_sel_n;
      lt_addr_q <= lt_addr;
      rt_addr_q <= rt_addr;
      if (!hit) begin
        lt_busy_n <= 1'b1;
        rt_busy_n <= 1'b1;
      end else if (!owned) begin
        lt_busy_n <= !rt_first;
        rt_busy_n <= rt_first;
      end
    end
  end

endmodule

module dp_collision_arb_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              lt_sel_n,
  input logic [ADDR_W-1:0] lt_addr,
  input logic              rt_sel_n,
  input logic [ADDR_W-1:0] rt_addr,
  input logic              lt_busy_n,
  input logic              rt_busy_n
);

  logic same_loc;
  assign same_loc = !lt_sel_n && !rt_sel_n && (lt_addr == rt_addr);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (lt_busy_n && rt_busy_n));

  assert_unselected_R2: assert property (@(posedge clk) disable iff (rst)
    (lt_sel_n || rt_sel_n) |=> (lt_busy_n && rt_busy_n));

  assert_apart_R3: assert property (@(posedge clk) disable iff (rst)
    (lt_addr != rt_addr) |=> (lt_busy_n && rt_busy_n));

  assert_left_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (!rt_busy_n && same_loc) |=> !rt_busy_n);

  assert_right_kept_R6: assert property (@(posedge clk) disable iff (rst)
    (!lt_busy_n && same_loc) |=> !lt_busy_n);

  assert_flag_on_hit_R4: assert property (@(posedge clk) disable iff (rst)
    same_loc |=> (!lt_busy_n || !rt_busy_n));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    !(!lt_busy_n && !rt_busy_n));

endmodule

bind dp_collision_arb dp_collision_arb_chk #(.ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_dp_collision_arb.sv
`timescale 1ns/1ps
module test_dp_collision_arb;
  localparam int AW = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lt_sel_n = 1'b1, rt_sel_n = 1'b1;
  logic [AW-1:0] lt_addr = '0, rt_addr = '0;
  logic lt_busy_n, rt_busy_n;

  always #10 clk = ~clk;

  dp_collision_arb #(.ADDR_W(AW)) i_dp_collision_arb (
    .clk(clk), .rst(rst),
    .lt_sel_n(lt_sel_n), .lt_addr(lt_addr),
    .rt_sel_n(rt_sel_n), .rt_addr(rt_addr),
    .lt_busy_n(lt_busy_n), .rt_busy_n(rt_busy_n)
  );

  // behavioural reference: arrival cycle per side, owner 0 none, 1 left, 2 right
  int cyc = 0, arr_l = 0, arr_r = 0, owner = 0;
  logic pl_sel = 1'b1, pr_sel = 1'b1;
  logic [AW-1:0] pl_a = '0, pr_a = '0;
  int vectors = 0, errors = 0;
  string tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      owner = 0;
      pl_sel = 1'b1; pr_sel = 1'b1; pl_a = '0; pr_a = '0;
      arr_l = cyc; arr_r = cyc;
    end else begin
      if (lt_sel_n != pl_sel || lt_addr != pl_a) arr_l = cyc;
      if (rt_sel_n != pr_sel || rt_addr != pr_a) arr_r = cyc;
      if (!lt_sel_n && !rt_sel_n && lt_addr == rt_addr) begin
        if (owner == 0) owner = (arr_r < arr_l) ? 2 : 1;
      end else begin
        owner = 0;
      end
      pl_sel = lt_sel_n; pr_sel = rt_sel_n; pl_a = lt_addr; pr_a = rt_addr;
    end
    cyc++;
  end

  task automatic step(input logic ls, input int la, input logic rs, input int ra);
    logic el, er;
    @(posedge clk);
    #5;
    el = (owner != 2);
    er = (owner != 1);
    vectors++;
    if (lt_busy_n !== el || rt_busy_n !== er) begin
      errors++;
      $display("FAIL %s: busy l/r = %b/%b expected %b/%b at cycle %0d",
               tag, lt_busy_n, rt_busy_n, el, er, cyc);
    end
    if (!lt_busy_n && !rt_busy_n) begin
      errors++;
      $display("FAIL R9: busy l/r = %b/%b expected not both 0", lt_busy_n, rt_busy_n);
    end
    lt_sel_n = ls; lt_addr = AW'(la); rt_sel_n = rs; rt_addr = AW'(ra);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run not finished, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    tag = "R1";
    step(1, 0, 1, 0); step(1, 0, 1, 0);
    rst = 1'b0;
    step(1, 0, 1, 0);
    tag = "R2";
    step(0, 5, 1, 5); step(0, 5, 1, 5); step(1, 5, 0, 5); step(1, 5, 0, 5);
    tag = "R3";
    step(0, 5, 0, 6); step(0, 5, 0, 6); step(0, 7, 1, 7);
    tag = "R4";                               // left steady at 7, right joins
    step(0, 7, 0, 7); step(0, 7, 0, 7); step(0, 7, 0, 7);
    tag = "R7";
    step(0, 7, 0, 8); step(1, 0, 0, 9); step(1, 0, 0, 9);
    tag = "R4";                               // right steady at 9, left joins
    step(0, 9, 0, 9); step(0, 9, 0, 9); step(0, 9, 0, 9);
    tag = "R8";                               // winner (right) deselects
    step(0, 9, 1, 9); step(1, 0, 1, 0); step(1, 0, 1, 0);
    tag = "R5";                               // same-cycle arrival
    step(0, 3, 0, 3); step(0, 3, 0, 3); step(0, 3, 0, 3);
    tag = "R6";                               // right wins at 4, then joint move to 6
    step(1, 0, 0, 4); step(1, 0, 0, 4); step(0, 4, 0, 4); step(0, 4, 0, 4);
    step(0, 6, 0, 6); step(0, 6, 0, 6); step(0, 6, 0, 6);
    tag = "R1";                               // reset mid-collision
    rst = 1'b1;
    step(0, 6, 0, 6);
    rst = 1'b0;
    step(0, 6, 0, 6); step(0, 6, 0, 6); step(1, 0, 1, 0);
    tag = "R4";                               // mixed random run
    for (int i = 0; i < 600; i++)
      step(logic'($urandom_range(0, 3) == 0), $urandom_range(0, 3),
           logic'($urandom_range(0, 3) == 0), $urandom_range(0, 3));
    step(1, 0, 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule